// File: doc/BRIEF.md
# Inter-Core Mailbox with Built-In Memory-Read Responder

This block is a two-sided mailbox between a host core and a service side. The host posts a command on a register-mapped bus port. It writes a request address into the request data word, then a request code into the request control word, and that write raises a request-valid flag. The service side is a small built-in engine. It decodes the code, reads one word from RAM through a simple request/valid memory port, and fills the response data word. It then raises response-valid together with a response code in one write.

The transaction ends in a strict four-phase order. The host reads the reply and clears response-valid. The engine sees the clear and drops request-valid. The host starts the next command only once request-valid reads back low.

A second, read-only bus port lets the service core observe all four mailbox words. Two level interrupts follow the two valid flags.

Top module: `mbx_link`

## Requirements
- R1: After reset, both valid flags, the sticky error bit, both interrupts and the memory request are low, and every mailbox word reads as zero.
- R2: A host write to word 0 (request control) while request-valid is low stores bits [7:0] as the request code and sets request-valid, readable at bit 8 of word 0, from the next cycle. The service interrupt is high exactly while request-valid is set.
- R3: A host write to word 0 while request-valid is set leaves the stored code unchanged and sets a sticky error bit, readable at bit 9 of word 0. The error bit stays set until reset.
- R4: A host write to word 1 (request data) while request-valid is set is ignored.
- R5: Request code 0x02 causes exactly one single-cycle memory request, whose address equals the request data word.
- R6: The memory read data is in the response data word (word 3) no later than the cycle in which response-valid rises, and it is unchanged in that cycle.
- R7: A single internal post sets the response code (word 2, bits [7:0]) and response-valid (word 2, bit 8) in the same cycle. For a RAM read the code is 0x02.
- R8: Any other request code is answered with response code 0xFF and response data 0, and no memory request is issued.
- R9: The host interrupt is high exactly while response-valid is set.
- R10: A host write to word 2 with bit 8 low clears response-valid. A write to word 2 with bit 8 high has no effect.
- R11: Request-valid is cleared only after response-valid has been seen low, and never while response-valid is set.
- R12: Once request-valid reads low, a new host request is accepted and served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 2 | Host word select |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data (combinational from h_addr) |
| s_addr | input | 2 | Service-side observation word select |
| s_rdata | output | DATA_W | Service-side read data |
| svc_irq | output | 1 | Interrupt to the service core, follows request-valid |
| host_irq | output | 1 | Interrupt to the host, follows response-valid |
| mem_req | output | 1 | Single-cycle memory read request |
| mem_addr | output | DATA_W | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The bench builds the block with its default 16-bit data width. At that width the error bit and both valid bits share a control word with the 8-bit code. The bench memory answers three cycles after each request. That latency holds request-valid high long enough for the rejected control write and the ignored data write to land mid-transaction. The width also lets the reply data carry a value computed from the whole 16-bit address, so a wrong or stale address shows up in the reply.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int CODE_W    = 8;
  localparam int VALID_BIT = 8;
  localparam int ERR_BIT   = 9;

  localparam logic [CODE_W-1:0] CODE_RAM_RD = 8'h02;
  localparam logic [CODE_W-1:0] CODE_BAD    = 8'hFF;

  typedef enum logic [1:0] {
    REG_REQ_CTRL = 2'd0,
    REG_REQ_DATA = 2'd1,
    REG_RSP_CTRL = 2'd2,
    REG_RSP_DATA = 2'd3
  } mbx_reg_e;

  typedef enum logic [2:0] {
    SV_IDLE   = 3'd0,
    SV_DECODE = 3'd1,
    SV_WAIT   = 3'd2,
    SV_POST   = 3'd3,
    SV_HOLD   = 3'd4,
    SV_CLOSE  = 3'd5
  } sv_state_e;

  function automatic logic is_ram_read(input logic [CODE_W-1:0] c);
    return c == CODE_RAM_RD;
  endfunction

  function automatic logic [CODE_W-1:0] reply_code(input logic [CODE_W-1:0] c);
    return is_ram_read(c) ? CODE_RAM_RD : CODE_BAD;
  endfunction
endpackage

// File: rtl/mbx_host_side.sv
module mbx_host_side
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                h_wr,
  input  logic [1:0]          h_addr,
  input  logic [DATA_W-1:0]   h_wdata,
  input  logic                req_close,
  input  logic                rsp_valid,
  output logic                req_valid,
  output logic [CODE_W-1:0]   req_code,
  output logic [DATA_W-1:0]   req_data,
  output logic                req_err,
  output logic                req_accept,
  output logic                req_reject,
  output logic                rsp_ack
);
  logic wr_ctrl, wr_data, wr_rsp;

  assign wr_ctrl = h_wr && (h_addr == REG_REQ_CTRL);
  assign wr_data = h_wr && (h_addr == REG_REQ_DATA);
  assign wr_rsp  = h_wr && (h_addr == REG_RSP_CTRL);

  assign req_accept = wr_ctrl && !req_valid;
  assign req_reject = wr_ctrl &&  req_valid;
  assign rsp_ack    = wr_rsp && !h_wdata[VALID_BIT] && rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_code  <= '0;
      req_data  <= '0;
      req_err   <= 1'b0;
    end else begin
      if (req_accept) begin
        req_code  <= h_wdata[CODE_W-1:0];
        req_valid <= 1'b1;
      end else if (req_close) begin
        req_valid <= 1'b0;
      end
      if (req_reject) req_err <= 1'b1;
      if (wr_data && !req_valid) req_data <= h_wdata;
    end
  end
endmodule

// File: rtl/mbx_rsp_regs.sv
module mbx_rsp_regs
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_wr,
  input  logic [DATA_W-1:0]   data_in,
  input  logic                post,
  input  logic [CODE_W-1:0]   post_code,
  input  logic                ack,
  output logic                rsp_valid,
  output logic [CODE_W-1:0]   rsp_code,
  output logic [DATA_W-1:0]   rsp_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      rsp_data  <= '0;
    end else begin
      if (data_wr) rsp_data <= data_in;
      if (post) begin
        rsp_code  <= post_code;
        rsp_valid <= 1'b1;
      end else if (ack) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbx_service_engine.sv
module mbx_service_engine
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [CODE_W-1:0]   req_code,
  input  logic [DATA_W-1:0]   req_data,
  input  logic                rsp_valid,
  input  logic                mem_rvalid,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                mem_req,
  output logic [DATA_W-1:0]   mem_addr,
  output logic                data_wr,
  output logic [DATA_W-1:0]   data_out,
  output logic                post,
  output logic [CODE_W-1:0]   post_code,
  output logic                req_close
);
  sv_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    mem_req   = 1'b0;
    data_wr   = 1'b0;
    data_out  = '0;
    post      = 1'b0;
    req_close = 1'b0;
    unique case (state_q)
      SV_IDLE:   if (req_valid) state_d = SV_DECODE;
      SV_DECODE: begin
        if (is_ram_read(req_code)) begin
          mem_req = 1'b1;
          state_d = SV_WAIT;
        end else begin
          data_wr = 1'b1;
          state_d = SV_POST;
        end
      end
      SV_WAIT: begin
        if (mem_rvalid) begin
          data_wr  = 1'b1;
          data_out = mem_rdata;
          state_d  = SV_POST;
        end
      end
      SV_POST: begin
        post    = 1'b1;
        state_d = SV_HOLD;
      end
      SV_HOLD:  if (!rsp_valid) state_d = SV_CLOSE;
      SV_CLOSE: begin
        req_close = 1'b1;
        state_d   = SV_IDLE;
      end
      default:  state_d = SV_IDLE;
    endcase
  end

  assign mem_addr  = req_data;
  assign post_code = reply_code(req_code);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SV_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/mbx_link.sv
module mbx_link
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [1:0]        h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  input  logic [1:0]        s_addr,
  output logic [DATA_W-1:0] s_rdata,
  output logic              svc_irq,
  output logic              host_irq,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int N_PORTS = 2;

  logic              req_valid, req_err, req_accept, req_reject, rsp_ack, req_close;
  logic [CODE_W-1:0] req_code, rsp_code, post_code;
  logic [DATA_W-1:0] req_data, rsp_data, eng_data;
  logic              rsp_valid, eng_data_wr, rsp_post;

  mbx_host_side #(.DATA_W(DATA_W)) host_i (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .req_close(req_close), .rsp_valid(rsp_valid), .req_valid(req_valid),
    .req_code(req_code), .req_data(req_data), .req_err(req_err),
    .req_accept(req_accept), .req_reject(req_reject), .rsp_ack(rsp_ack)
  );

  mbx_service_engine #(.DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_data(req_data), .rsp_valid(rsp_valid), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .data_wr(eng_data_wr), .data_out(eng_data), .post(rsp_post),
    .post_code(post_code), .req_close(req_close)
  );

  mbx_rsp_regs #(.DATA_W(DATA_W)) rsp_i (
    .clk(clk), .rst_n(rst_n), .data_wr(eng_data_wr), .data_in(eng_data),
    .post(rsp_post), .post_code(post_code), .ack(rsp_ack),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data)
  );

  assign svc_irq  = req_valid;
  assign host_irq = rsp_valid;

  logic [1:0]        port_addr [N_PORTS];
  logic [DATA_W-1:0] port_word [N_PORTS];

  assign port_addr[0] = h_addr;
  assign port_addr[1] = s_addr;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_rd
    always_comb begin
      port_word[p] = '0;
      unique case (mbx_reg_e'(port_addr[p]))
        REG_REQ_CTRL: begin
          port_word[p][CODE_W-1:0] = req_code;
          port_word[p][VALID_BIT]  = req_valid;
          port_word[p][ERR_BIT]    = req_err;
        end
        REG_REQ_DATA: port_word[p] = req_data;
        REG_RSP_CTRL: begin
          port_word[p][CODE_W-1:0] = rsp_code;
          port_word[p][VALID_BIT]  = rsp_valid;
        end
        REG_RSP_DATA: port_word[p] = rsp_data;
        default:      port_word[p] = '0;
      endcase
    end
  end

  assign h_rdata = port_word[0];
  assign s_rdata = port_word[1];
endmodule

// File: rtl/mbx_link_chk.sv
module mbx_link_chk
  import mbx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_wr,
  input logic [1:0]        h_addr,
  input logic [DATA_W-1:0] h_wdata,
  input logic              req_valid,
  input logic [CODE_W-1:0] req_code,
  input logic              req_err,
  input logic              rsp_valid,
  input logic [CODE_W-1:0] rsp_code,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_req
);
  // R2
  accept_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == REG_REQ_CTRL && !req_valid) |=> req_valid);

  // R3
  reject_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == REG_REQ_CTRL && req_valid) |=> (req_err && $stable(req_code)));

  // R5
  mem_req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (req_valid && !rsp_valid && req_code == CODE_RAM_RD));

  // R5
  mem_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R6
  data_before_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $stable(rsp_data));

  // R7
  post_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (rsp_code == reply_code(req_code)));

  // R10
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == REG_RSP_CTRL && !h_wdata[VALID_BIT] && rsp_valid) |=> !rsp_valid);

  // R11
  close_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_valid) |-> !$past(rsp_valid));
endmodule

bind mbx_link mbx_link_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
  .req_valid(req_valid), .req_code(req_code), .req_err(req_err),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
  .mem_req(mem_req)
);

// File: tb/mbx_link_tb.sv
module mbx_link_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          h_wr = 1'b0;
  logic [1:0]    h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic [DW-1:0] h_rdata;
  logic [1:0]    s_addr = '0;
  logic [DW-1:0] s_rdata;
  logic          svc_irq, host_irq, mem_req, mem_rvalid;
  logic [DW-1:0] mem_addr, mem_rdata;

  int checks = 0;
  int errors = 0;
  int mem_req_cnt = 0;
  logic [DW-1:0] last_mem_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_link #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .s_addr(s_addr), .s_rdata(s_rdata), .svc_irq(svc_irq),
    .host_irq(host_irq), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: three-cycle read latency
  function automatic logic [DW-1:0] mem_model(input logic [DW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + 8'h11};
  endfunction

  logic          pv0 = 1'b0, pv1 = 1'b0, pv2 = 1'b0;
  logic [DW-1:0] pa0 = '0, pa1 = '0, pa2 = '0;
  always @(posedge clk) begin
    pv0 <= mem_req; pa0 <= mem_addr;
    pv1 <= pv0;     pa1 <= pa0;
    pv2 <= pv1;     pa2 <= pa1;
    if (mem_req) begin
      mem_req_cnt <= mem_req_cnt + 1;
      last_mem_addr <= mem_addr;
    end
  end
  assign mem_rvalid = pv2;
  assign mem_rdata  = mem_model(pa2);

  typedef struct packed {
    logic [7:0]    code;
    logic [DW-1:0] data;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    h_addr = a;
    #1 d = h_rdata;
  endtask

  task automatic issue(input logic [7:0] code, input logic [DW-1:0] addr);
    exp_t e;
    e.code = (code == 8'h02) ? 8'h02 : 8'hFF;
    e.data = (code == 8'h02) ? mem_model(addr) : '0;
    sb_q.push_back(e);
    hwrite(2'd1, addr);
    hwrite(2'd0, {8'h00, code});
  endtask

  task automatic finish_txn(input logic [DW-1:0] exp_data);
    logic [DW-1:0] d;
    int tries;
    while (!host_irq) @(negedge clk);
    repeat (2) @(negedge clk);
    hread(2'd3, d);
    chk(d == exp_data, "R6 host reply data", d, exp_data);
    hread(2'd0, d);
    chk(d[8] == 1'b1, "R11 request held while reply pending", d[8], 1);
    hwrite(2'd2, 16'h0000);
    chk(host_irq == 1'b0, "R10 clear write drops host irq", host_irq, 0);
    tries = 0;
    d = 16'hFFFF;
    while (d[8] && tries < 20) begin
      hread(2'd0, d);
      tries++;
    end
    chk(d[8] == 1'b0 && svc_irq == 1'b0, "R11 request closed after ack", d[8], 0);
  endtask

  // monitor: pops expected reply when host irq rises
  initial begin
    logic seen = 1'b0;
    logic [DW-1:0] c, d;
    exp_t e;
    forever begin
      @(negedge clk);
      if (host_irq && !seen) begin
        seen = 1'b1;
        s_addr = 2'd2;
        #1 c = s_rdata;
        s_addr = 2'd3;
        #1 d = s_rdata;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R7 unexpected reply", c, 0);
        end else begin
          e = sb_q.pop_front();
          chk(c[8] == 1'b1 && c[7:0] == e.code, "R7 reply code with valid", c, {8'h01, e.code});
          chk(d == e.data, "R6 reply data at post", d, e.data);
          chk(host_irq == c[8], "R9 host irq follows valid", host_irq, c[8]);
        end
      end
      if (!host_irq) seen = 1'b0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    hread(2'd0, d); chk(d == 0, "R1 request control at reset", d, 0);
    hread(2'd2, d); chk(d == 0, "R1 response control at reset", d, 0);
    hread(2'd3, d); chk(d == 0, "R1 response data at reset", d, 0);
    chk(!svc_irq && !host_irq && !mem_req, "R1 irqs and mem idle", {svc_irq, host_irq, mem_req}, 0);

    // R2 / R3 / R4 with a RAM read in flight
    issue(8'h02, 16'h1234);
    hread(2'd0, d);
    chk(d[8] && d[7:0] == 8'h02 && svc_irq, "R2 request accepted", d, 16'h0102);
    hwrite(2'd0, 16'h0055);
    hread(2'd0, d);
    chk(d[7:0] == 8'h02 && d[9] == 1'b1, "R3 rejected write sets error keeps code", d, 16'h0302);
    hwrite(2'd1, 16'hBEEF);
    hread(2'd1, d);
    chk(d == 16'h1234, "R4 data write ignored while pending", d, 16'h1234);
    while (!host_irq) @(negedge clk);
    hwrite(2'd2, 16'h0100);
    chk(host_irq == 1'b1, "R10 write with flag high no effect", host_irq, 1);
    finish_txn(mem_model(16'h1234));
    chk(mem_req_cnt == 1 && last_mem_addr == 16'h1234, "R5 one request at data address", last_mem_addr, 16'h1234);

    // R8 unknown code, R12 next request after close
    base = mem_req_cnt;
    issue(8'h37, 16'h4444);
    hread(2'd0, d);
    chk(d[8] && d[9], "R12 new request accepted error sticky", d[9:8], 2'b11);
    finish_txn(16'h0000);
    chk(mem_req_cnt == base, "R8 no memory access for unknown code", mem_req_cnt, base);

    // R5 / R7 several reads
    for (int i = 0; i < 4; i++) begin
      logic [DW-1:0] a;
      a = 16'h0F0F * (i + 1) + 16'h0101;
      issue(8'h02, a);
      finish_txn(mem_model(a));
      chk(last_mem_addr == a, "R5 memory address matches request", last_mem_addr, a);
    end
    chk(mem_req_cnt == base + 4, "R5 one memory request per read", mem_req_cnt, base + 4);
    chk(sb_q.size() == 0, "R7 every request answered", sb_q.size(), 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule